// File: doc/BRIEF.md
# Four-Bit Lookahead Carry Adder Slice

This block adds two 4-bit operands and a carry-in in pure combinational logic. It does not pass a carry from one bit position to the next. It first forms a generate term and a propagate term for each bit. It then builds every internal carry and the carry-out as a flat two-level sum of products of those terms and the carry-in. Each sum bit is the exclusive-or of the two operand bits and the carry that enters that position.

The block also reports a group generate and a group propagate. A higher lookahead stage uses these to predict this slice's carry-out without waiting for it, so the slice can sit inside a two-level hierarchical adder. The slice width is a parameter with a default of 4. It must not exceed 4, because wider groups need product terms whose gate fan-in is above five. All inputs and outputs are active-high and nothing is registered.

Top module: `cla4_group`

## Requirements
- R1: `sum_o` equals the low four bits of the arithmetic value `a_i + b_i + cin_i`, for every combination of inputs.
- R2: `cout_o` equals bit 4 (value 16) of `a_i + b_i + cin_i`.
- R3: `grp_gen_o` is 1 exactly when `a_i + b_i` is 16 or more, so the slice makes a carry by itself. It does not depend on `cin_i`.
- R4: `grp_prop_o` is 1 exactly when every bit position has at least one operand bit set (`(a_i | b_i) == 4'hF`). It does not depend on `cin_i`.
- R5: `cout_o` always equals `grp_gen_o | (grp_prop_o & cin_i)`, so a higher lookahead stage can rebuild the carry-out from the group outputs.
- R6: On the longest carry path, where every position propagates and none generates (`a_i ^ b_i == 4'hF`, `a_i & b_i == 0`), `cin_i = 1` gives `sum_o = 0` and `cout_o = 1`, and `cin_i = 0` gives `sum_o = 4'hF` and `cout_o = 0`.
- R7: The block holds no state. With all inputs at zero, all outputs are zero, and an output depends only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| cin_i | input | 1 | Carry into the least significant position |
| sum_o | output | 4 | Sum bits |
| cout_o | output | 1 | Carry out of the most significant position |
| grp_gen_o | output | 1 | Group generate, for a higher lookahead stage |
| grp_prop_o | output | 1 | Group propagate, for a higher lookahead stage |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between an input and an output. The bench applies one input set shortly after each rising clock edge. It compares all four outputs against its arithmetic model at the following falling edge, once the logic has settled, and changes nothing in between. The bench steps through all 512 combinations of the operands and the carry-in. It also places the all-propagate chain and the zero state on cycles of their own.

// File: rtl/cla_pkg.sv
package cla_pkg;
    // Width of one lookahead slice; limited to 4 by the five-input fan-in budget.
    parameter int unsigned GRP_W = 4;

    // Per-position carry terms.
    typedef struct packed {
        logic gen;
        logic prop;
    } bit_term_t;
endpackage

// File: rtl/cla_term_gen.sv
module cla_term_gen #(
    parameter int unsigned W = cla_pkg::GRP_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);
    import cla_pkg::*;

    bit_term_t [W-1:0] term_d;

    for (genvar i = 0; i < W; i++) begin : g_pos
        always_comb begin
            term_d[i].gen  = a_i[i] & b_i[i];
            term_d[i].prop = a_i[i] | b_i[i];
            // A position that generates must also propagate (used by R3/R4 group terms).
            p_gen_within_prop_r3: assert (!term_d[i].gen || term_d[i].prop)
                else $error("generate without propagate at position %0d", i);
        end
        assign gen_o[i]  = term_d[i].gen;
        assign prop_o[i] = term_d[i].prop;
    end
endmodule

// File: rtl/cla_carry_net.sv
module cla_carry_net #(
    parameter int unsigned W = cla_pkg::GRP_W
) (
    input  logic [W-1:0] gen_i,
    input  logic [W-1:0] prop_i,
    input  logic         cin_i,
    output logic [W:0]   carry_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    logic [W:0] carry_d;
    logic       grp_gen_d;
    logic       grp_prop_d;
    logic       acc;
    logic       term;
    logic       tail;
    logic       rip;

    // Each carry is one OR of AND terms over gen/prop and cin only.
    always_comb begin
        carry_d    = '0;
        carry_d[0] = cin_i;
        acc  = 1'b0;
        term = 1'b0;
        tail = 1'b0;
        rip  = cin_i;
        for (int k = 0; k < int'(W); k++) begin
            acc = 1'b0;
            for (int j = 0; j <= k; j++) begin
                term = gen_i[j];
                for (int m = j + 1; m <= k; m++) begin
                    term = term & prop_i[m];
                end
                acc = acc | term;
            end
            tail = cin_i;
            for (int m = 0; m <= k; m++) begin
                tail = tail & prop_i[m];
            end
            carry_d[k+1] = acc | tail;
            // Independent serial form of the same carry.
            rip = gen_i[k] | (prop_i[k] & rip);
            p_carry_ripple_match_r2: assert (carry_d[k+1] == rip)
                else $error("flat carry %0d differs from serial form", k + 1);
        end
    end

    // Group terms for the next lookahead level.
    always_comb begin
        grp_gen_d  = 1'b0;
        grp_prop_d = &prop_i;
        for (int j = 0; j < int'(W); j++) begin
            logic t;
            t = gen_i[j];
            for (int m = j + 1; m < int'(W); m++) begin
                t = t & prop_i[m];
            end
            grp_gen_d = grp_gen_d | t;
        end
    end

    always_comb begin
        p_group_gen_carry_r5: assert (!grp_gen_d || carry_d[W])
            else $error("group generate without carry out");
        p_group_prop_carry_r5: assert (!(grp_prop_d && cin_i) || carry_d[W])
            else $error("group propagate with carry in but no carry out");
        p_group_kill_r5: assert (grp_gen_d || (grp_prop_d && cin_i) || !carry_d[W])
            else $error("carry out with neither group term");
    end

    assign carry_o    = carry_d;
    assign grp_gen_o  = grp_gen_d;
    assign grp_prop_o = grp_prop_d;
endmodule

// File: rtl/cla_sum_xor.sv
module cla_sum_xor #(
    parameter int unsigned W = cla_pkg::GRP_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] carry_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] sum_d;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            sum_d[i] = a_i[i] ^ b_i[i] ^ carry_i[i];
            // With no carry in, a sum bit is set only if exactly one operand bit is.
            p_sum_halfadd_r1: assert (carry_i[i] || (sum_d[i] == (a_i[i] != b_i[i])))
                else $error("sum bit %0d wrong with no incoming carry", i);
        end
    end

    assign sum_o = sum_d;
endmodule

// File: rtl/cla4_group.sv
module cla4_group #(
    parameter int unsigned W = cla_pkg::GRP_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    logic [W-1:0] gen_w;
    logic [W-1:0] prop_w;
    logic [W:0]   carry_w;

    cla_term_gen #(.W(W)) u_terms (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (gen_w),
        .prop_o (prop_w)
    );

    cla_carry_net #(.W(W)) u_carry (
        .gen_i      (gen_w),
        .prop_i     (prop_w),
        .cin_i      (cin_i),
        .carry_o    (carry_w),
        .grp_gen_o  (grp_gen_o),
        .grp_prop_o (grp_prop_o)
    );

    cla_sum_xor #(.W(W)) u_sum (
        .a_i     (a_i),
        .b_i     (b_i),
        .carry_i (carry_w[W-1:0]),
        .sum_o   (sum_o)
    );

    assign cout_o = carry_w[W];
endmodule

// File: tb/cla4_group_tb_top.sv
`timescale 1ns/1ps
module cla4_group_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a, b;
    logic       cin;
    logic [3:0] sum;
    logic       cout, gg, gp;
    int         total_chk = 0;
    int         bad_chk = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    cla4_group dut_i (
        .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout), .grp_gen_o(gg), .grp_prop_o(gp)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total_chk++;
        if (act != exp) begin
            bad_chk++;
            $display("FAIL %s %s: actual=%0d expected=%0d (a=%0d b=%0d cin=%0d)",
                     req, what, act, exp, a, b, cin);
        end
    endtask

    task automatic apply(input int av, input int bv, input int cv);
        @(posedge clk);
        #1;
        a = 4'(av); b = 4'(bv); cin = 1'(cv);
        @(negedge clk);
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: zero inputs held under reset give all-zero outputs
        check("R7", "sum at rest",  int'(sum),  0);
        check("R7", "cout at rest", int'(cout), 0);
        check("R7", "gg at rest",   int'(gg),   0);
        check("R7", "gp at rest",   int'(gp),   0);
        rst_n = 1'b1;

        // R6: longest chain, every position propagates, none generates
        apply(4'b1010, 4'b0101, 1);
        check("R6", "chain sum",  int'(sum),  0);
        check("R6", "chain cout", int'(cout), 1);
        check("R6", "chain gp",   int'(gp),   1);
        apply(4'b1010, 4'b0101, 0);
        check("R6", "chain sum no cin",  int'(sum),  15);
        check("R6", "chain cout no cin", int'(cout), 0);

        // Exhaustive sweep against an arithmetic model
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int c = 0; c < 2; c++) begin
                    int tot;
                    apply(x, y, c);
                    tot = x + y + c;
                    check("R1", "sum",  int'(sum),  tot % 16);
                    check("R2", "cout", int'(cout), (tot >= 16) ? 1 : 0);
                    check("R3", "grp_gen",  int'(gg), ((x + y) >= 16) ? 1 : 0);
                    check("R4", "grp_prop", int'(gp), ((x | y) == 15) ? 1 : 0);
                    check("R5", "cout from group", int'(cout),
                          (((x + y) >= 16) || (((x | y) == 15) && c == 1)) ? 1 : 0);
                end
            end
        end

        // R7: returning to zero inputs clears every output, nothing retained
        apply(15, 15, 1);
        apply(0, 0, 0);
        check("R7", "sum after return",  int'(sum),  0);
        check("R7", "cout after return", int'(cout), 0);
        check("R7", "gg after return",   int'(gg),   0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total_chk++;
            bad_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
            $finish;
        end
    end
endmodule